// File: doc/BRIEF.md
# Register-Driven Bus Transaction Bridge

This block lets software run single transactions on a downstream request/acknowledge bus through a 32-bit register port. Software first loads a direction, a transfer width (byte, halfword or word), a target address and, for writes, a data word into separate registers. A write to the launch register then starts one transaction built from those values. The bridge holds a request on the downstream bus until the target answers. The answer can be a halfword acknowledge, a fullword acknowledge, an error or a retry.

Retries are counted against a programmable limit. A missing answer ends the transfer after a fixed number of cycles. Every finished transfer sets a sticky completion flag, which software clears by writing one to a clear register. The completion flag drives an interrupt line when its mask bit is set. A per-transfer status register records which kinds of answer were seen. For reads, a read-data register holds the returned word, cut down to the transfer width.

Top module: `cmd_bus_bridge`

## Requirements
- R1: After reset the completion flag, transfer status, interrupt line and downstream request are all zero, and the retry-limit register (offset 0x64) reads 16.
- R2: A register write of value with bit 0 set to offset 0x04 while idle launches a transaction. One cycle later dn_req is high, and dn_read, dn_size, dn_addr and dn_wdata carry the command (offset 0x14, bit 0 = 1 read, 0 write), size (offset 0x18), address (0x1C) and write data (0x20). These outputs stay stable while dn_req is high.
- R3: Size codes are 0 byte, 1 halfword, 3 word. A launch with any other size value raises no request, finishes at once and leaves only status bit 2 (error) set.
- R4: Response codes on dn_rsp end the transfer and set a bit in the status register at offset 0x80. Code 0 (halfword ack) sets bit 0, code 1 (fullword ack) sets bit 1, and code 2 (error) sets bit 2. Code 3 (retry) sets bit 3.
- R5: Each completion sets bit 16 of the interrupt status register (offset 0x48). A write to offset 0x40 with bit 0 set clears it. A write there with bit 0 clear leaves it unchanged.
- R6: The irq output equals interrupt status bit 16 AND bit 16 of the mask register (offset 0x44).
- R7: On a read acknowledged with code 0 or 1, the read-data register (offset 0x84) holds the returned data masked to its low 8 bits for a byte, its low 16 bits for a halfword, and all 32 bits for a word.
- R8: With retry limit L, up to L retry responses keep the request asserted. The retry that would be number L+1 ends the transfer with status bits 3 and 2 both set.
- R9: If no response arrives for TIMEOUT_CYC consecutive cycles of a request, the transfer ends with status bit 4 set and completion flagged.
- R10: A launch write during a transfer is ignored, and the in-flight request is unchanged. An accepted launch clears the status register.
- R11: The command, size, address, write-data, channel-select (offset 0x10, bit 0) and mask registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after the address |
| irq | output | 1 | Masked completion interrupt |
| dn_req | output | 1 | Downstream request, held until answered |
| dn_read | output | 1 | Downstream direction, 1 = read |
| dn_size | output | 2 | Downstream transfer width code |
| dn_addr | output | 32 | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp | input | 2 | Response code: 0 half ack, 1 full ack, 2 error, 3 retry |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The bench sweeps every pairing of direction, valid width and ending response. It uses data patterns that expose a masking mistake: a bridge that skipped masking would return the upper bytes on a byte read. It crosses retry limits 0 to 3 with retry counts up to one past the limit. An off-by-one in the limit compare would release the request a retry early or hold it a retry too long. The timeout is probed on the exact cycle before and at expiry. Illegal size codes (2, 4, 7, a high bit) must finish without touching the bus. A launch repeated mid-transfer must not move the address. Clear writes with bit 0 low must leave the completion flag set.

// File: rtl/cmd_bus_bridge_pkg.sv
package cmd_bus_bridge_pkg;
  typedef enum logic [1:0] {
    RSP_HALF  = 2'd0,
    RSP_FULL  = 2'd1,
    RSP_ERR   = 2'd2,
    RSP_RETRY = 2'd3
  } rsp_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

  localparam int OFF_LAUNCH = 'h04;
  localparam int OFF_CHSEL  = 'h10;
  localparam int OFF_CMD    = 'h14;
  localparam int OFF_SIZE   = 'h18;
  localparam int OFF_ADDR   = 'h1C;
  localparam int OFF_WDATA  = 'h20;
  localparam int OFF_ICLR   = 'h40;
  localparam int OFF_IMASK  = 'h44;
  localparam int OFF_ISTAT  = 'h48;
  localparam int OFF_RLIM   = 'h64;
  localparam int OFF_XSTAT  = 'h80;
  localparam int OFF_RDATA  = 'h84;

  localparam int XS_HALF  = 0;
  localparam int XS_FULL  = 1;
  localparam int XS_ERR   = 2;
  localparam int XS_RETRY = 3;
  localparam int XS_TMO   = 4;
  localparam int XS_W     = 5;

  localparam int DONE_BIT = 16;
endpackage

// File: rtl/cmd_bus_bridge_seq.sv
module cmd_bus_bridge_seq
  import cmd_bus_bridge_pkg::*;
#(
  parameter int DW          = 32,
  parameter int LIM_W       = 8,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             cfg_read,
  input  logic [31:0]      cfg_size,
  input  logic [DW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [LIM_W-1:0] retry_lim,
  output logic             busy,
  output logic             done,
  output logic [XS_W-1:0]  xstat,
  output logic             rd_cap,
  output logic [DW-1:0]    rd_val,
  output logic             dn_req,
  output logic             dn_read,
  output logic [1:0]       dn_size,
  output logic [DW-1:0]    dn_addr,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_rsp_valid,
  input  logic [1:0]       dn_rsp,
  input  logic [DW-1:0]    dn_rdata
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  seq_state_e       state;
  logic [TMO_W-1:0] tmo_cnt;
  logic [LIM_W-1:0] retry_cnt;
  logic             size_ok;
  logic [DW-1:0]    rd_mask;
  rsp_e             rsp;

  assign size_ok = (cfg_size == 32'd0) || (cfg_size == 32'd1) || (cfg_size == 32'd3);
  assign busy    = (state == ST_WAIT);
  assign rsp     = rsp_e'(dn_rsp);

  always_comb begin
    case (dn_size)
      2'd0:    rd_mask = DW'({8{1'b1}});
      2'd1:    rd_mask = DW'({16{1'b1}});
      default: rd_mask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tmo_cnt   <= '0;
      retry_cnt <= '0;
      done      <= 1'b0;
      xstat     <= '0;
      rd_cap    <= 1'b0;
      rd_val    <= '0;
      dn_req    <= 1'b0;
      dn_read   <= 1'b0;
      dn_size   <= '0;
      dn_addr   <= '0;
      dn_wdata  <= '0;
    end else begin
      done   <= 1'b0;
      rd_cap <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            xstat     <= '0;
            tmo_cnt   <= '0;
            retry_cnt <= '0;
            if (size_ok) begin
              state    <= ST_WAIT;
              dn_req   <= 1'b1;
              dn_read  <= cfg_read;
              dn_size  <= cfg_size[1:0];
              dn_addr  <= cfg_addr;
              dn_wdata <= cfg_wdata;
            end else begin
              done         <= 1'b1;
              xstat[XS_ERR] <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            tmo_cnt <= '0;
            case (rsp)
              RSP_HALF, RSP_FULL: begin
                xstat[(rsp == RSP_HALF) ? XS_HALF : XS_FULL] <= 1'b1;
                state  <= ST_IDLE;
                dn_req <= 1'b0;
                done   <= 1'b1;
                if (dn_read) begin
                  rd_cap <= 1'b1;
                  rd_val <= dn_rdata & rd_mask;
                end
              end
              RSP_ERR: begin
                xstat[XS_ERR] <= 1'b1;
                state  <= ST_IDLE;
                dn_req <= 1'b0;
                done   <= 1'b1;
              end
              default: begin
                xstat[XS_RETRY] <= 1'b1;
                if (retry_cnt == retry_lim) begin
                  xstat[XS_ERR] <= 1'b1;
                  state  <= ST_IDLE;
                  dn_req <= 1'b0;
                  done   <= 1'b1;
                end else begin
                  retry_cnt <= retry_cnt + 1'b1;
                end
              end
            endcase
          end else if (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1)) begin
            xstat[XS_TMO] <= 1'b1;
            state  <= ST_IDLE;
            dn_req <= 1'b0;
            done   <= 1'b1;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_bus_bridge_csr.sv
module cmd_bus_bridge_csr
  import cmd_bus_bridge_pkg::*;
#(
  parameter int CSR_AW    = 8,
  parameter int DW        = 32,
  parameter int LIM_W     = 8,
  parameter int LIM_RESET = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  output logic             launch,
  output logic             cfg_read,
  output logic [31:0]      cfg_size,
  output logic [DW-1:0]    cfg_addr,
  output logic [DW-1:0]    cfg_wdata,
  output logic [LIM_W-1:0] retry_lim,
  output logic             done_flag,
  output logic             done_mask,
  input  logic             done,
  input  logic [XS_W-1:0]  xstat,
  input  logic             rd_cap,
  input  logic [DW-1:0]    rd_val
);
  logic          chsel;
  logic [DW-1:0] rd_hold;

  function automatic logic hit(input logic [CSR_AW-1:0] a, input int off);
    return a == CSR_AW'(off);
  endfunction

  assign launch = csr_wr && hit(csr_addr, OFF_LAUNCH) && csr_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_read  <= 1'b0;
      cfg_size  <= '0;
      cfg_addr  <= '0;
      cfg_wdata <= '0;
      retry_lim <= LIM_W'(LIM_RESET);
      chsel     <= 1'b0;
      done_mask <= 1'b0;
      done_flag <= 1'b0;
      rd_hold   <= '0;
    end else begin
      if (csr_wr) begin
        if (hit(csr_addr, OFF_CMD))   cfg_read  <= csr_wdata[0];
        if (hit(csr_addr, OFF_SIZE))  cfg_size  <= csr_wdata;
        if (hit(csr_addr, OFF_ADDR))  cfg_addr  <= DW'(csr_wdata);
        if (hit(csr_addr, OFF_WDATA)) cfg_wdata <= DW'(csr_wdata);
        if (hit(csr_addr, OFF_RLIM))  retry_lim <= csr_wdata[LIM_W-1:0];
        if (hit(csr_addr, OFF_CHSEL)) chsel     <= csr_wdata[0];
        if (hit(csr_addr, OFF_IMASK)) done_mask <= csr_wdata[DONE_BIT];
      end
      if (done) done_flag <= 1'b1;
      else if (csr_wr && hit(csr_addr, OFF_ICLR) && csr_wdata[0]) done_flag <= 1'b0;
      if (rd_cap) rd_hold <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else begin
      csr_rdata <= '0;
      if (hit(csr_addr, OFF_CHSEL)) csr_rdata <= {31'd0, chsel};
      if (hit(csr_addr, OFF_CMD))   csr_rdata <= {31'd0, cfg_read};
      if (hit(csr_addr, OFF_SIZE))  csr_rdata <= cfg_size;
      if (hit(csr_addr, OFF_ADDR))  csr_rdata <= 32'(cfg_addr);
      if (hit(csr_addr, OFF_WDATA)) csr_rdata <= 32'(cfg_wdata);
      if (hit(csr_addr, OFF_RLIM))  csr_rdata <= 32'(retry_lim);
      if (hit(csr_addr, OFF_IMASK)) csr_rdata[DONE_BIT] <= done_mask;
      if (hit(csr_addr, OFF_ISTAT)) csr_rdata[DONE_BIT] <= done_flag;
      if (hit(csr_addr, OFF_XSTAT)) csr_rdata <= 32'(xstat);
      if (hit(csr_addr, OFF_RDATA)) csr_rdata <= 32'(rd_hold);
    end
  end
endmodule

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge
  import cmd_bus_bridge_pkg::*;
#(
  parameter int CSR_AW      = 8,
  parameter int LIM_W       = 8,
  parameter int LIM_RESET   = 16,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq,
  output logic              dn_req,
  output logic              dn_read,
  output logic [1:0]        dn_size,
  output logic [31:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [1:0]        dn_rsp,
  input  logic [31:0]       dn_rdata
);
  localparam int DW = 32;

  logic             launch, cfg_read, busy, done, rd_cap, done_flag, done_mask;
  logic [31:0]      cfg_size;
  logic [DW-1:0]    cfg_addr, cfg_wdata, rd_val;
  logic [LIM_W-1:0] retry_lim;
  logic [XS_W-1:0]  xstat;

  cmd_bus_bridge_csr #(
    .CSR_AW(CSR_AW), .DW(DW), .LIM_W(LIM_W), .LIM_RESET(LIM_RESET)
  ) u_csr (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .launch(launch),
    .cfg_read(cfg_read), .cfg_size(cfg_size), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .retry_lim(retry_lim), .done_flag(done_flag),
    .done_mask(done_mask), .done(done), .xstat(xstat), .rd_cap(rd_cap),
    .rd_val(rd_val)
  );

  cmd_bus_bridge_seq #(
    .DW(DW), .LIM_W(LIM_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .cfg_read(cfg_read),
    .cfg_size(cfg_size), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .retry_lim(retry_lim), .busy(busy), .done(done), .xstat(xstat),
    .rd_cap(rd_cap), .rd_val(rd_val), .dn_req(dn_req), .dn_read(dn_read),
    .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp(dn_rsp), .dn_rdata(dn_rdata)
  );

  assign irq = done_flag & done_mask;
endmodule

// File: rtl/cmd_bus_bridge_chk.sv
module cmd_bus_bridge_chk
  import cmd_bus_bridge_pkg::*;
#(
  parameter int CSR_AW      = 8,
  parameter int TIMEOUT_CYC = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_wr,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [31:0]       csr_wdata,
  input logic              irq,
  input logic              dn_req,
  input logic [31:0]       dn_addr,
  input logic [1:0]        dn_size,
  input logic              dn_rsp_valid,
  input logic [1:0]        dn_rsp,
  input logic              busy,
  input logic              done,
  input logic [31:0]       cfg_size,
  input logic [XS_W-1:0]   xstat
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  logic [CW-1:0] wait_cnt;
  logic          trig, size_ok;

  assign trig    = csr_wr && (csr_addr == CSR_AW'(OFF_LAUNCH)) && csr_wdata[0];
  assign size_ok = (cfg_size == 32'd0) || (cfg_size == 32'd1) || (cfg_size == 32'd3);

  always_ff @(posedge clk) begin
    if (rst || !dn_req || dn_rsp_valid) wait_cnt <= '0;
    else wait_cnt <= wait_cnt + 1'b1;
  end

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (trig && !busy && size_ok) |=> dn_req);

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (dn_req && $past(dn_req)) |-> ($stable(dn_addr) && $stable(dn_size)));

  p_bad_size_r3: assert property (@(posedge clk) disable iff (rst)
    (trig && !busy && !size_ok) |=> (!dn_req && done && xstat == 5'b00100));

  p_ack_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_rsp_valid && dn_rsp != 2'd3) |=> (!dn_req && done));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == CSR_AW'(OFF_ICLR) && csr_wdata[0] && !done) |=> !irq);

  p_timeout_r9: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_rsp_valid && wait_cnt == CW'(TIMEOUT_CYC - 1)) |=> (!dn_req && xstat[XS_TMO]));
endmodule

bind cmd_bus_bridge cmd_bus_bridge_chk #(
  .CSR_AW(CSR_AW), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .irq(irq), .dn_req(dn_req), .dn_addr(dn_addr),
  .dn_size(dn_size), .dn_rsp_valid(dn_rsp_valid), .dn_rsp(dn_rsp),
  .busy(busy), .done(done), .cfg_size(cfg_size), .xstat(xstat)
);

// File: tb/cmd_bus_bridge_tb.sv
module cmd_bus_bridge_tb;
  localparam int TMO = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq, dn_req, dn_read;
  logic [1:0]  dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [1:0]  dn_rsp = '0;
  logic [31:0] dn_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cmd_bus_bridge #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .dn_req(dn_req), .dn_read(dn_read), .dn_size(dn_size),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp(dn_rsp), .dn_rdata(dn_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic respond(input logic [1:0] code, input logic [31:0] data);
    @(negedge clk);
    dn_rsp_valid = 1'b1; dn_rsp = code; dn_rdata = data;
    @(posedge clk);
    @(negedge clk);
    dn_rsp_valid = 1'b0;
  endtask

  task automatic load(input logic rdc, input logic [31:0] sz,
                      input logic [31:0] a, input logic [31:0] d);
    wr(8'h14, {31'd0, rdc});
    wr(8'h18, sz);
    wr(8'h1C, a);
    wr(8'h20, d);
    wr(8'h40, 32'h1);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, msk, pat;
    logic [1:0] szc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 dn_req", {31'd0, dn_req}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(8'h64, v); check("R1 retry limit", v, 32'd16);
    rd(8'h80, v); check("R1 xstat", v, 0);
    rd(8'h48, v); check("R1 istat", v, 0);

    // R2 R4 R6 R7 sweep direction x size x ending code
    for (int dir = 0; dir < 2; dir++) begin
      for (int si = 0; si < 3; si++) begin
        for (int code = 0; code < 3; code++) begin
          szc = (si == 2) ? 2'd3 : 2'(si);
          pat = 32'hA5C3_0000 ^ (32'(dir) << 28) ^ (32'(si) << 8) ^ 32'(code);
          wr(8'h44, {15'd0, 1'(code[0]), 16'd0});
          load(1'(dir), 32'(szc), pat ^ 32'h0F0F_0F0F, ~pat);
          wr(8'h04, 32'h1);
          check("R2 dn_req", {31'd0, dn_req}, 1);
          check("R2 dn_read", {31'd0, dn_read}, 32'(dir));
          check("R2 dn_size", {30'd0, dn_size}, 32'(szc));
          check("R2 dn_addr", dn_addr, pat ^ 32'h0F0F_0F0F);
          check("R2 dn_wdata", dn_wdata, ~pat);
          respond(2'(code), 32'hDEAD_BEEF ^ pat);
          check("R4 req drops", {31'd0, dn_req}, 0);
          rd(8'h80, v); check("R4 xstat", v, 32'd1 << code);
          rd(8'h48, v); check("R5 istat set", v, 32'h0001_0000);
          check("R6 irq", {31'd0, irq}, 32'(code[0]));
          if (dir == 1 && code < 2) begin
            msk = (szc == 2'd0) ? 32'hFF : (szc == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
            rd(8'h84, v); check("R7 read data", v, (32'hDEAD_BEEF ^ pat) & msk);
          end
        end
      end
    end

    // R5 clear with bit0 low keeps flag, bit0 high clears
    wr(8'h44, 32'h0001_0000);
    wr(8'h40, 32'hFFFF_FFFE);
    rd(8'h48, v); check("R5 clear bit0 low ignored", v, 32'h0001_0000);
    check("R6 irq masked on", {31'd0, irq}, 1);
    wr(8'h40, 32'h1);
    rd(8'h48, v); check("R5 cleared", v, 0);
    check("R6 irq after clear", {31'd0, irq}, 0);

    // R3 illegal sizes
    foreach (pat[i]) begin
      if (i < 4) begin
        v = (i == 0) ? 32'd2 : (i == 1) ? 32'd4 : (i == 2) ? 32'd7 : 32'h100;
        load(1'b0, v, 32'h1234, 32'h5678);
        wr(8'h04, 32'h1);
        check("R3 no request", {31'd0, dn_req}, 0);
        rd(8'h80, v); check("R3 xstat error only", v, 32'h4);
        rd(8'h48, v); check("R3 completion", v, 32'h0001_0000);
      end
    end

    // R8 retry limit sweep
    for (int lim = 0; lim < 4; lim++) begin
      for (int nret = 0; nret <= lim + 1; nret++) begin
        wr(8'h64, 32'(lim));
        load(1'b0, 32'd3, 32'h4000 + 32'(lim * 8 + nret), 32'h0);
        wr(8'h04, 32'h1);
        for (int k = 0; k < nret; k++) begin
          respond(2'd3, 32'h0);
          check("R8 request held", {31'd0, dn_req}, (k < lim) ? 32'd1 : 32'd0);
        end
        if (nret <= lim) begin
          respond(2'd1, 32'h0);
          rd(8'h80, v); check("R8 retry then ack", v, (nret > 0) ? 32'hA : 32'h2);
        end else begin
          rd(8'h80, v); check("R8 abandoned", v, 32'hC);
        end
        rd(8'h48, v); check("R8 completion", v, 32'h0001_0000);
      end
    end
    wr(8'h64, 32'd16);

    // R9 timeout exactly at TMO cycles
    load(1'b1, 32'd0, 32'h77, 32'h0);
    wr(8'h04, 32'h1);
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk);
    check("R9 still waiting", {31'd0, dn_req}, 1);
    @(posedge clk);
    @(negedge clk);
    check("R9 timed out", {31'd0, dn_req}, 0);
    rd(8'h80, v); check("R9 xstat", v, 32'h10);
    rd(8'h48, v); check("R9 completion", v, 32'h0001_0000);

    // R10 relaunch ignored in flight, status cleared on launch
    load(1'b0, 32'd3, 32'hAAAA_0000, 32'h1);
    wr(8'h04, 32'h1);
    wr(8'h1C, 32'hBBBB_0000);
    wr(8'h04, 32'h1);
    check("R10 addr unchanged", dn_addr, 32'hAAAA_0000);
    check("R10 still one request", {31'd0, dn_req}, 1);
    respond(2'd1, 32'h0);
    rd(8'h80, v); check("R10 first status", v, 32'h2);
    wr(8'h04, 32'h1);
    rd(8'h80, v); check("R10 status cleared on launch", v, 0);
    check("R10 new addr", dn_addr, 32'hBBBB_0000);
    respond(2'd0, 32'h0);
    rd(8'h80, v); check("R10 second status", v, 32'h1);

    // R11 readback
    wr(8'h10, 32'h1); rd(8'h10, v); check("R11 chsel", v, 32'h1);
    wr(8'h14, 32'h1); rd(8'h14, v); check("R11 cmd", v, 32'h1);
    wr(8'h18, 32'h3); rd(8'h18, v); check("R11 size", v, 32'h3);
    wr(8'h1C, 32'hCAFE_F00D); rd(8'h1C, v); check("R11 addr", v, 32'hCAFE_F00D);
    wr(8'h20, 32'h0BAD_1DEA); rd(8'h20, v); check("R11 wdata", v, 32'h0BAD_1DEA);
    wr(8'h44, 32'h0001_0000); rd(8'h44, v); check("R11 mask", v, 32'h0001_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule